// File: doc/BRIEF.md
# Radix-Adjusted Memory Increment Unit

This unit executes one member of a 4-bit processor's instruction set. The instruction reads a nibble from data memory, adds one to it, and wraps the sum to a radix between 1 and 16. It then writes the result back to the same location. The radix is carried in the opcode. The memory address comes from either the X or the Y index register. One opcode form also advances that index register after the write.

When the plain form runs while an extension prefix is pending, the 8-bit extension byte replaces the index register as the address. With X it addresses page 0000H, and with Y it addresses page FF00H. The post-increment form ignores the prefix.

The surrounding core pulses `start` together with the instruction word and the current register values. The unit spends one cycle on the read and one cycle on the write. It hands back the updated index registers and flags together with the write. The core drives the memory through an address, separate read and write strobes, and a combinational read-data return.

Top module: `radix_inc_unit`

## Requirements
- R1: A `start` pulse is accepted only when `instr[12:6]` equals 7'b1110110, which covers codes 1D80H to 1DBFH. Bit 5 selects Y (1) or X (0), and bit 4 selects the post-increment form. Any other code causes no memory access and leaves every output unchanged.
- R2: The radix n4 equals 16 minus `instr[3:0]`, so a code of 0 gives a radix of 16 and a code of FH gives a radix of 1.
- R3: Let s = nibble + 1. If s >= n4, the written value is s - n4 and C (flags_out bit 1) is 1. Otherwise the written value is s and C is 0.
- R4: Z (flags_out bit 0) is 1 exactly when the written nibble is 0. E (bit 3) is cleared. I (bit 2) takes the `iflag_in` value captured with the instruction.
- R5: In the cycle after an accepting edge, `mem_rd` is 1 with the address. In the next cycle, `mem_wr` is 1 at the same address, with `mem_wdata`, `done`, the flags and the index outputs all valid.
- R6: With no prefix pending, the address is the selected index register.
- R7: With a prefix pending on the plain form, the address is {00H, ext_byte} for X and {FFH, ext_byte} for Y.
- R8: In the post-increment form, the prefix is ignored and the selected index register is output plus one, wrapping from FFFFH to 0000H. The other index register, and both registers in the plain form, are output unchanged. Flags do not depend on the pointer update.
- R9: A `start` arriving during the read cycle is ignored. A `start` arriving during the write cycle is accepted, so instructions can run back to back at one every two cycles.
- R10: Synchronous reset drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse for the instruction on `instr` |
| instr | input | 13 | Instruction word |
| ext_pending | input | 1 | Extension prefix is pending |
| ext_byte | input | 8 | Extension byte |
| x_in | input | 16 | Current X register |
| y_in | input | 16 | Current Y register |
| iflag_in | input | 1 | Current I flag |
| mem_rdata | input | 4 | Combinational read data from memory |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 4 | Adjusted nibble to write |
| x_out | output | 16 | Updated X |
| y_out | output | 16 | Updated Y |
| flags_out | output | 4 | {E, I, C, Z} |
| done | output | 1 | Result and register updates valid |

## Verification
Assertions check the following properties on every cycle:
- The read and write strobes are never high together.
- Every read is followed by a write at an unchanged address.
- Two reads are never adjacent.
- E is low whenever results are valid.
- Z agrees with the written nibble.
- The adjusted nibble stays below the radix whenever the value that was read was already in range.

Only the scoreboard scenarios can show the following behaviours:
- The exact arithmetic and carry across radixes 1, 10 and 16.
- The page-0000H and page-FF00H prefix addressing, and the prefix being ignored in the post-increment form.
- The 16-bit pointer wrap.
- Ignored opcodes.
- The rule that a second `start` is accepted in the write cycle but not in the read cycle.

// File: rtl/radix_inc_pkg.sv
package radix_inc_pkg;
  localparam int DATA_W = 4;
  localparam int ADDR_W = 16;
  localparam int INSTR_W = 13;
  localparam int EXT_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic             valid;
    logic             use_y;
    logic             post;
    logic [DATA_W:0]  radix;
  } dec_t;
endpackage

// File: rtl/rinc_decode.sv
module rinc_decode
  import radix_inc_pkg::*;
#(
  parameter int OPW = INSTR_W,
  parameter int DW = DATA_W,
  parameter logic [OPW-7:0] MATCH = 7'b1110110
) (
  input  logic [OPW-1:0] instr_i,
  output dec_t           dec_o
);
  localparam logic [DW:0] RADIX_TOP = (DW+1)'(1) << DW;

  always_comb begin
    dec_o.valid = (instr_i[OPW-1:6] == MATCH);
    dec_o.use_y = instr_i[5];
    dec_o.post  = instr_i[4];
    dec_o.radix = RADIX_TOP - {1'b0, instr_i[DW-1:0]};
  end
endmodule

// File: rtl/rinc_addr_sel.sv
module rinc_addr_sel #(
  parameter int AW = 16,
  parameter int EW = 8,
  parameter logic [AW-EW-1:0] LO_PAGE = '0,
  parameter logic [AW-EW-1:0] HI_PAGE = '1
) (
  input  logic          ext_i,
  input  logic [EW-1:0] imm_i,
  input  logic          use_y_i,
  input  logic          post_i,
  input  logic [AW-1:0] x_i,
  input  logic [AW-1:0] y_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] idx;
  logic [AW-1:0] paged;

  always_comb begin
    idx    = use_y_i ? y_i : x_i;
    paged  = {(use_y_i ? HI_PAGE : LO_PAGE), imm_i};
    addr_o = (ext_i && !post_i) ? paged : idx;
  end
endmodule

// File: rtl/rinc_adjust.sv
module rinc_adjust #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] nib_i,
  input  logic [DW:0]   radix_i,
  output logic [DW-1:0] res_o,
  output logic          carry_o
);
  logic [DW:0] sum;
  logic [DW:0] wrapped;

  always_comb begin
    sum     = {1'b0, nib_i} + (DW+1)'(1);
    wrapped = sum - radix_i;
    carry_o = (sum >= radix_i);
    res_o   = carry_o ? wrapped[DW-1:0] : sum[DW-1:0];
  end

  always_comb begin
    if ({1'b0, nib_i} < radix_i) begin
      a_r3_in_range: assert ({1'b0, res_o} < radix_i);
    end
  end
endmodule

// File: rtl/radix_inc_unit.sv
module radix_inc_unit
  import radix_inc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [INSTR_W-1:0]  instr,
  input  logic                ext_pending,
  input  logic [EXT_W-1:0]    ext_byte,
  input  logic [ADDR_W-1:0]   x_in,
  input  logic [ADDR_W-1:0]   y_in,
  input  logic                iflag_in,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [ADDR_W-1:0]   x_out,
  output logic [ADDR_W-1:0]   y_out,
  output logic [3:0]          flags_out,
  output logic                done
);
  localparam int NIDX = 2;

  seq_state_t        state_q;
  dec_t              dec;
  logic              accept;
  logic [ADDR_W-1:0] addr_nxt;
  logic [DATA_W-1:0] adj_res;
  logic              adj_carry;

  logic              cap_use_y;
  logic              cap_post;
  logic              cap_iflag;
  logic [DATA_W:0]   cap_radix;
  logic [ADDR_W-1:0] idx_in  [NIDX];
  logic [ADDR_W-1:0] cap_idx [NIDX];
  logic [ADDR_W-1:0] nxt_idx [NIDX];

  rinc_decode #(.OPW(INSTR_W), .DW(DATA_W)) u_dec (
    .instr_i(instr),
    .dec_o  (dec)
  );

  rinc_addr_sel #(.AW(ADDR_W), .EW(EXT_W)) u_addr (
    .ext_i  (ext_pending),
    .imm_i  (ext_byte),
    .use_y_i(dec.use_y),
    .post_i (dec.post),
    .x_i    (x_in),
    .y_i    (y_in),
    .addr_o (addr_nxt)
  );

  rinc_adjust #(.DW(DATA_W)) u_adj (
    .nib_i  (mem_rdata),
    .radix_i(cap_radix),
    .res_o  (adj_res),
    .carry_o(adj_carry)
  );

  assign accept    = start && dec.valid && (state_q != ST_READ);
  assign idx_in[0] = x_in;
  assign idx_in[1] = y_in;

  for (genvar i = 0; i < NIDX; i++) begin : g_idx
    assign nxt_idx[i] = (cap_post && (cap_use_y == 1'(i))) ?
                        cap_idx[i] + ADDR_W'(1) : cap_idx[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
      x_out     <= '0;
      y_out     <= '0;
      flags_out <= '0;
      done      <= 1'b0;
      cap_use_y <= 1'b0;
      cap_post  <= 1'b0;
      cap_iflag <= 1'b0;
      cap_radix <= '0;
      for (int k = 0; k < NIDX; k++) cap_idx[k] <= '0;
    end else begin
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      done   <= 1'b0;
      if (accept) begin
        state_q   <= ST_READ;
        mem_rd    <= 1'b1;
        mem_addr  <= addr_nxt;
        cap_use_y <= dec.use_y;
        cap_post  <= dec.post;
        cap_radix <= dec.radix;
        cap_iflag <= iflag_in;
        for (int k = 0; k < NIDX; k++) cap_idx[k] <= idx_in[k];
      end else if (state_q == ST_READ) begin
        state_q   <= ST_WRITE;
        mem_wr    <= 1'b1;
        mem_wdata <= adj_res;
        flags_out <= {1'b0, cap_iflag, adj_carry, (adj_res == '0)};
        x_out     <= nxt_idx[0];
        y_out     <= nxt_idx[1];
        done      <= 1'b1;
      end else begin
        state_q <= ST_IDLE;
      end
    end
  end

  a_r5_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  a_r5_read_then_write: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> (mem_wr && done));
  a_r5_addr_held: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> $stable(mem_addr));
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(mem_rd));
  a_r9_no_adjacent_reads: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);
  a_r4_e_cleared: assert property (@(posedge clk) disable iff (rst)
    done |-> !flags_out[3]);
  a_r4_z_tracks_data: assert property (@(posedge clk) disable iff (rst)
    done |-> (flags_out[0] == (mem_wdata == '0)));
endmodule

// File: tb/tb_radix_inc_unit.sv
`timescale 1ns/1ps
module tb_radix_inc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [12:0] instr = '0;
  logic        ext_pending = 1'b0;
  logic [7:0]  ext_byte = '0;
  logic [15:0] x_in = '0;
  logic [15:0] y_in = '0;
  logic        iflag_in = 1'b0;
  logic [3:0]  mem_rdata = '0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, done;
  logic [3:0]  mem_wdata, flags_out;
  logic [15:0] x_out, y_out;

  radix_inc_unit dut (.*);

  always #4 clk = ~clk;

  typedef struct packed {
    logic [15:0] addr;
    logic [3:0]  wdata;
    logic [3:0]  flags;
    logic [15:0] x;
    logic [15:0] y;
  } exp_t;

  exp_t     sbq[$];
  bit [3:0] mem [int];
  bit [3:0] ref_mem [int];
  int       n_chk = 0;
  int       n_fail = 0;
  bit       finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic preload(input logic [15:0] a, input logic [3:0] v);
    mem[int'(a)] = v;
    ref_mem[int'(a)] = v;
  endtask

  // Caller sits at a negedge; returns one negedge later.
  task automatic issue(input logic [12:0] op, input logic ext, input logic [7:0] imm,
                       input logic [15:0] xv, input logic [15:0] yv, input logic ifl,
                       input bit accepted);
    exp_t        e;
    logic        use_y, post, c;
    logic [4:0]  n4, s;
    logic [3:0]  nib, res;
    logic [15:0] a;
    instr = op; ext_pending = ext; ext_byte = imm;
    x_in = xv; y_in = yv; iflag_in = ifl; start = 1'b1;
    if (accepted) begin
      use_y = op[5]; post = op[4];
      n4 = 5'd16 - {1'b0, op[3:0]};
      a = (ext && !post) ? (use_y ? {8'hFF, imm} : {8'h00, imm}) : (use_y ? yv : xv);
      nib = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 4'h0;
      s = {1'b0, nib} + 5'd1;
      if (s >= n4) begin res = 4'(s - n4); c = 1'b1; end
      else begin res = s[3:0]; c = 1'b0; end
      ref_mem[int'(a)] = res;
      e.addr = a; e.wdata = res;
      e.flags = {1'b0, ifl, c, res == 4'h0};
      e.x = (post && !use_y) ? xv + 16'd1 : xv;
      e.y = (post && use_y) ? yv + 16'd1 : yv;
      sbq.push_back(e);
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run1(input logic [12:0] op, input logic ext, input logic [7:0] imm,
                      input logic [15:0] xv, input logic [15:0] yv, input logic ifl);
    issue(op, ext, imm, xv, yv, ifl, 1'b1);
    @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares against scoreboard, models combinational-read memory.
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd) begin
        if (sbq.size() == 0) chk(1'b0, "R1", "unexpected read addr", 32'(mem_addr), 32'h0);
        else chk(mem_addr == sbq[0].addr, "R6", "read addr (R7 paging)",
                 32'(mem_addr), 32'(sbq[0].addr));
      end
      if (mem_wr) begin
        if (sbq.size() == 0) chk(1'b0, "R9", "unexpected write", 32'(mem_addr), 32'h0);
        else begin
          exp_t e;
          e = sbq.pop_front();
          chk(mem_addr == e.addr, "R5", "write addr", 32'(mem_addr), 32'(e.addr));
          chk(done == 1'b1, "R5", "done with write", 32'(done), 32'h1);
          chk(mem_wdata == e.wdata, "R3", "wdata", 32'(mem_wdata), 32'(e.wdata));
          chk(flags_out[1] == e.flags[1], "R3", "carry", 32'(flags_out[1]), 32'(e.flags[1]));
          chk(flags_out == e.flags, "R4", "flags EICZ", 32'(flags_out), 32'(e.flags));
          chk(x_out == e.x, "R8", "x_out", 32'(x_out), 32'(e.x));
          chk(y_out == e.y, "R8", "y_out", 32'(y_out), 32'(e.y));
        end
        mem[int'(mem_addr)] = mem_wdata;
      end
    end
    mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 4'h0;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      chk(1'b0, "R5", "watchdog expired", 32'(cyc), 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] hx, hy;
    logic [3:0]  hf;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(mem_rd == 0 && mem_wr == 0 && done == 0, "R10", "strobes after reset",
        {29'h0, mem_rd, mem_wr, done}, 32'h0);
    chk(mem_addr == 0 && mem_wdata == 0, "R10", "addr/data after reset",
        {12'h0, mem_addr, mem_wdata}, 32'h0);
    chk(x_out == 0 && y_out == 0 && flags_out == 0, "R10", "regs after reset",
        {x_out, y_out}, 32'h0);

    // R2/R3 radix 16: F -> 0 carry; 7 -> 8
    preload(16'h0040, 4'hF); run1(13'h1D80, 0, 8'h00, 16'h0040, 16'h1234, 1'b0);
    preload(16'h0041, 4'h7); run1(13'h1D80, 0, 8'h00, 16'h0041, 16'h1234, 1'b1);
    // R2 radix 10 (code 6): 9 -> 0 carry, 5 -> 6
    preload(16'h0050, 4'h9); run1(13'h1D86, 0, 8'h00, 16'h0050, 16'h0000, 1'b0);
    preload(16'h0051, 4'h5); run1(13'h1D86, 0, 8'h00, 16'h0051, 16'h0000, 1'b0);
    // R2 radix 1 (code F): always 0, carry
    preload(16'h0060, 4'h0); run1(13'h1DAF, 0, 8'h00, 16'h0000, 16'h0060, 1'b1);
    // R6 Y plain, no prefix
    preload(16'hBEEF, 4'h3); run1(13'h1DA0, 0, 8'h00, 16'h1111, 16'hBEEF, 1'b0);
    // R7 prefix on plain X -> 00imm, Y -> FFimm
    preload(16'h00A5, 4'h2); run1(13'h1D80, 1, 8'hA5, 16'h7777, 16'h8888, 1'b0);
    preload(16'hFF3C, 4'h4); run1(13'h1DA8, 1, 8'h3C, 16'h7777, 16'h8888, 1'b0);
    // R8 post-increment ignores prefix, wraps FFFF
    preload(16'hFFFF, 4'h1); run1(13'h1D90, 1, 8'h12, 16'hFFFF, 16'h4444, 1'b0);
    preload(16'hFFFF, 4'h1); run1(13'h1DB3, 1, 8'h12, 16'h0001, 16'hFFFF, 1'b1);
    // R4: I passthrough, E cleared
    preload(16'h0070, 4'h8); run1(13'h1D97, 0, 8'h00, 16'h0070, 16'h0002, 1'b1);

    // R1 invalid opcodes: no access, outputs unchanged
    hx = x_out; hy = y_out; hf = flags_out;
    issue(13'h1DC3, 0, 8'h00, 16'h0001, 16'h0002, 1'b0, 1'b0);
    issue(13'h0D85, 0, 8'h00, 16'h0003, 16'h0004, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      chk(!mem_rd && !mem_wr, "R1", "no access for invalid code",
          {30'h0, mem_rd, mem_wr}, 32'h0);
      @(negedge clk);
    end
    chk(x_out == hx && y_out == hy, "R1", "index outputs held", {x_out, y_out}, {hx, hy});
    chk(flags_out == hf, "R1", "flags held", 32'(flags_out), 32'(hf));

    // R9: start in read cycle ignored, start in write cycle accepted
    preload(16'h0200, 4'h4); preload(16'h0300, 4'h6); preload(16'h0400, 4'h1);
    issue(13'h1D80, 0, 8'h00, 16'h0200, 16'h0000, 1'b0, 1'b1);
    issue(13'h1D80, 0, 8'h00, 16'h0300, 16'h0000, 1'b0, 1'b0);
    issue(13'h1D80, 0, 8'h00, 16'h0400, 16'h0000, 1'b0, 1'b1);
    @(negedge clk);
    chk(mem_wr && mem_addr == 16'h0400, "R9", "back-to-back write addr",
        32'(mem_addr), 32'h0400);
    @(negedge clk);
    // R9 back-to-back on the same address sees previous write
    preload(16'h0500, 4'h8);
    issue(13'h1D86, 0, 8'h00, 16'h0500, 16'h0000, 1'b0, 1'b1);
    @(negedge clk);
    issue(13'h1D86, 0, 8'h00, 16'h0500, 16'h0000, 1'b0, 1'b1);
    @(negedge clk); @(negedge clk);
    chk(mem[32'h0500] == 4'h0, "R9", "chained result 8->9->0", 32'(mem[32'h0500]), 32'h0);

    // Random patterns, back to back
    for (int k = 0; k < 60; k++) begin
      logic [12:0] op;
      logic [15:0] rx, ry;
      op = {7'b1110110, 6'($urandom)};
      rx = 16'($urandom % 8); ry = 16'hFFF8 + 16'($urandom % 8);
      if (!mem.exists(int'(rx))) preload(rx, 4'($urandom));
      if (!mem.exists(int'(ry))) preload(ry, 4'($urandom));
      issue(op, 1'($urandom), 8'($urandom % 4), rx, ry, 1'($urandom), 1'b1);
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R5", "scoreboard drained", 32'(sbq.size()), 32'h0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule